// File: doc/BRIEF.md
# Integer ALU with Flag Generation

This block is a single-stage integer arithmetic and logic unit for 8-, 16- and 32-bit operands. It holds a six-bit status register: carry, parity, auxiliary carry, zero, sign and overflow. Every accepted command computes a result at the selected width and updates that register according to the rules of its operation. Carry-consuming operations read the register as it stands when they are accepted, so a chain of commands (add, then add-with-carry) can be issued back to back.

Commands enter on a valid/ready handshake and results leave on a second one. The block holds one result in an output register. `in_ready` is high when that register is empty or is being drained in the same cycle (`!out_valid || out_ready`). While `out_valid` is high and `out_ready` is low, the result, the write strobe and the flag register are frozen, and no new command is taken. A command is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result appears on the next cycle.

Two commands move the flags as one byte. One loads five flags from a byte operand. The other returns the packed flag byte as a result.

Top module: `alu_flag_unit`

## Requirements
- R1: A command is accepted when in_valid and in_ready are both high; out_valid rises on the next cycle. in_ready is low only while out_valid is high and out_ready is low, and during such a stall out_result, out_wr and out_flags hold. A drained output with no new command clears out_valid.
- R2: in_size 0, 1 and 2 select 8, 16 and 32 bits, and 3 acts as 32. Operands are taken from their low bits at that width. The result is zero above the width, and CF, OF and SF are taken at that width.
- R3: With in_imm8 high, in_a[7:0] is sign-extended to the selected width and used in place of in_a; the other bits of in_a are ignored.
- R4: Opcodes 0 ADD (b+a), 1 ADC (a+CF+b), 2 SUB (b-a) and 3 SBB (b-a-CF) write the masked result. CF is the carry out of, or the borrow into, the top bit.
- R5: Opcodes 4 CMP (b-a) and 10 TEST (b AND a) update the flags but set out_wr to 0 and out_result to 0.
- R6: Opcodes 5 INC (b+1) and 6 DEC (b-1) keep CF and update the other five flags.
- R7: Opcode 12 NEG writes 0-b. CF is 1 exactly when b was nonzero, and OF is 1 for the most negative value.
- R8: Opcodes 7 AND, 8 OR, 9 XOR and 10 TEST clear OF and CF, set SF, ZF and PF from the result, and keep AF.
- R9: Opcode 11 NOT writes the bitwise inverse of b at the width. NOT, opcode 14 and the reserved opcode 15 leave all flags unchanged. Opcode 15 also writes nothing (out_wr 0, result 0).
- R10: out_flags holds CF at bit 0, PF at bit 1, AF at bit 2, ZF at bit 3, SF at bit 4 and OF at bit 5. PF is 1 when result bits 7..0 hold an even number of ones, AF is the carry or borrow out of bit 3, and OF is signed overflow at the width.
- R11: Opcode 13 loads CF, PF, AF, ZF and SF from in_a bits 0, 2, 4, 6 and 7. It keeps OF and writes nothing.
- R12: Opcode 14 writes the packed flag byte, zero-extended: bit 0 CF, bit 2 PF, bit 4 AF, bit 6 ZF, bit 7 SF, with bits 1, 3 and 5 reading 0.
- R13: After reset, out_valid is 0, out_flags is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A command is presented |
| in_ready | output | 1 | The block can take a command |
| in_op | input | 4 | Operation code |
| in_size | input | 2 | Operand width select |
| in_a | input | 32 | Source operand (operand 1) |
| in_b | input | 32 | Destination operand (operand 2) |
| in_imm8 | input | 1 | Treat in_a[7:0] as a signed 8-bit immediate |
| out_valid | output | 1 | A result is held |
| out_ready | input | 1 | The consumer takes the held result |
| out_result | output | 32 | Result, zero above the selected width |
| out_wr | output | 1 | The result is to be written to the destination |
| out_flags | output | 6 | Flag register: OF, SF, ZF, AF, PF, CF from bit 5 down |

## Verification
The stall assertion assumes the consumer leaves a result in place only by holding out_ready low. It also assumes nothing but an accepted command touches the flag register. The bench therefore lowers out_ready in a single scenario, where it keeps changing the offered command to show that nothing moves. The carry and overflow assertions relate each accepted opcode to the flag register one cycle later, so they rely on in_op being one of the sixteen encodings. The stimulus changes inputs only on falling edges, and it uses the reserved encoding just once, to show that it has no effect.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int SZ_W = 2;
  localparam int NSEL = 1 << SZ_W;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBB  = 4'd3,
    OP_CMP  = 4'd4,
    OP_INC  = 4'd5,
    OP_DEC  = 4'd6,
    OP_AND  = 4'd7,
    OP_OR   = 4'd8,
    OP_XOR  = 4'd9,
    OP_TEST = 4'd10,
    OP_NOT  = 4'd11,
    OP_NEG  = 4'd12,
    OP_LDFB = 4'd13,
    OP_STFB = 4'd14,
    OP_NOP  = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } alu_flags_t;

  function automatic logic [7:0] pack_flag_byte(alu_flags_t f);
    return {f.sf, f.zf, 1'b0, f.af, 1'b0, f.pf, 1'b0, f.cf};
  endfunction

endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep
  import alu_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NSIZE = 3
) (
  input  logic [SZ_W-1:0] size_sel,
  input  logic [DW-1:0]   a_raw,
  input  logic [DW-1:0]   b_raw,
  input  logic            imm8,
  output logic [DW-1:0]   a_eff,
  output logic [DW-1:0]   b_eff,
  output logic [DW-1:0]   mask
);

  logic [DW-1:0] mask_tbl [NSEL];

  for (genvar gi = 0; gi < NSEL; gi++) begin : g_mask
    localparam int WI = (gi < NSIZE) ? (8 << gi) : (8 << (NSIZE - 1));
    assign mask_tbl[gi] = {DW{1'b1}} >> (DW - WI);
  end

  logic [DW-1:0] imm_ext;

  always_comb begin
    mask    = mask_tbl[size_sel];
    imm_ext = {{(DW-8){a_raw[7]}}, a_raw[7:0]};
    a_eff   = (imm8 ? imm_ext : a_raw) & mask;
    b_eff   = b_raw & mask;
  end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub
  import alu_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NSIZE = 3
) (
  input  logic [SZ_W-1:0] size_sel,
  input  logic [DW-1:0]   mask,
  input  logic [DW-1:0]   x,
  input  logic [DW-1:0]   y,
  input  logic            cin,
  input  logic            sub,
  output logic [DW-1:0]   r,
  output logic            co,
  output logic            af,
  output logic            of
);

  logic [DW:0] t;
  logic [NSEL-1:0] co_tbl, xs_tbl, ys_tbl, rs_tbl;

  always_comb begin
    if (sub) t = {1'b0, x} - {1'b0, y} - {{DW{1'b0}}, cin};
    else     t = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, cin};
  end

  for (genvar gi = 0; gi < NSEL; gi++) begin : g_tap
    localparam int WI = (gi < NSIZE) ? (8 << gi) : (8 << (NSIZE - 1));
    assign co_tbl[gi] = t[WI];
    assign xs_tbl[gi] = x[WI-1];
    assign ys_tbl[gi] = y[WI-1];
    assign rs_tbl[gi] = t[WI-1];
  end

  logic xs, ys, rs;

  always_comb begin
    xs = xs_tbl[size_sel];
    ys = ys_tbl[size_sel];
    rs = rs_tbl[size_sel];
    co = co_tbl[size_sel];
    r  = t[DW-1:0] & mask;
    af = x[4] ^ y[4] ^ t[4];
    if (sub) of = (xs != ys) && (rs != xs);
    else     of = (xs == ys) && (rs != xs);
  end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int DW = 32
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] mask,
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  output logic [DW-1:0] r
);

  always_comb begin
    case (op)
      OP_AND, OP_TEST: r = x & y;
      OP_OR:           r = x | y;
      OP_XOR:          r = x ^ y;
      OP_NOT:          r = ~x & mask;
      default:         r = '0;
    endcase
  end

endmodule

// File: rtl/alu_status.sv
module alu_status
  import alu_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NSIZE = 3
) (
  input  logic [SZ_W-1:0] size_sel,
  input  logic [DW-1:0]   r,
  output logic            zf,
  output logic            sf,
  output logic            pf
);

  logic [NSEL-1:0] top_tbl;

  for (genvar gi = 0; gi < NSEL; gi++) begin : g_top
    localparam int WI = (gi < NSIZE) ? (8 << gi) : (8 << (NSIZE - 1));
    assign top_tbl[gi] = r[WI-1];
  end

  always_comb begin
    zf = (r == '0);
    sf = top_tbl[size_sel];
    pf = ~^r[7:0];
  end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NSIZE = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [3:0]    in_op,
  input  logic [1:0]    in_size,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  input  logic          in_imm8,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_result,
  output logic          out_wr,
  output logic [5:0]    out_flags
);

  alu_op_e    op;
  alu_flags_t flags_q, flags_d;
  logic       accept;

  assign op       = alu_op_e'(in_op);
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  logic [DW-1:0] a_eff, b_eff, mask;

  alu_operand_prep #(.DW(DW), .NSIZE(NSIZE)) u_prep (
    .size_sel (in_size),
    .a_raw    (in_a),
    .b_raw    (in_b),
    .imm8     (in_imm8),
    .a_eff    (a_eff),
    .b_eff    (b_eff),
    .mask     (mask)
  );

  // Operand steering for the shared adder/subtractor
  logic [DW-1:0] as_x, as_y, as_r;
  logic          as_cin, as_sub, as_co, as_af, as_of;

  always_comb begin
    as_x   = b_eff;
    as_y   = a_eff;
    as_cin = 1'b0;
    as_sub = 1'b0;
    case (op)
      OP_ADC:         as_cin = flags_q.cf;
      OP_SUB, OP_CMP: as_sub = 1'b1;
      OP_SBB: begin
        as_sub = 1'b1;
        as_cin = flags_q.cf;
      end
      OP_INC:         as_y = DW'(1);
      OP_DEC: begin
        as_sub = 1'b1;
        as_y   = DW'(1);
      end
      OP_NEG: begin
        as_sub = 1'b1;
        as_x   = '0;
        as_y   = b_eff;
      end
      default: ;
    endcase
  end

  alu_addsub #(.DW(DW), .NSIZE(NSIZE)) u_addsub (
    .size_sel (in_size),
    .mask     (mask),
    .x        (as_x),
    .y        (as_y),
    .cin      (as_cin),
    .sub      (as_sub),
    .r        (as_r),
    .co       (as_co),
    .af       (as_af),
    .of       (as_of)
  );

  logic [DW-1:0] lg_r;

  alu_logic #(.DW(DW)) u_logic (
    .op   (op),
    .mask (mask),
    .x    (b_eff),
    .y    (a_eff),
    .r    (lg_r)
  );

  logic is_arith, is_logic;

  always_comb begin
    is_arith = op inside {OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP,
                          OP_INC, OP_DEC, OP_NEG};
    is_logic = op inside {OP_AND, OP_OR, OP_XOR, OP_TEST};
  end

  logic [DW-1:0] res_pick;
  logic          st_zf, st_sf, st_pf;

  assign res_pick = is_arith ? as_r : lg_r;

  alu_status #(.DW(DW), .NSIZE(NSIZE)) u_status (
    .size_sel (in_size),
    .r        (res_pick),
    .zf       (st_zf),
    .sf       (st_sf),
    .pf       (st_pf)
  );

  // Per-operation flag rules
  always_comb begin
    flags_d = flags_q;
    if (is_arith) begin
      flags_d.of = as_of;
      flags_d.sf = st_sf;
      flags_d.zf = st_zf;
      flags_d.af = as_af;
      flags_d.pf = st_pf;
      if (!(op inside {OP_INC, OP_DEC})) flags_d.cf = as_co;
    end else if (is_logic) begin
      flags_d.of = 1'b0;
      flags_d.cf = 1'b0;
      flags_d.sf = st_sf;
      flags_d.zf = st_zf;
      flags_d.pf = st_pf;
    end else if (op == OP_LDFB) begin
      flags_d.cf = in_a[0];
      flags_d.pf = in_a[2];
      flags_d.af = in_a[4];
      flags_d.zf = in_a[6];
      flags_d.sf = in_a[7];
    end
  end

  logic          wr_d;
  logic [DW-1:0] res_d;

  always_comb begin
    wr_d = !(op inside {OP_CMP, OP_TEST, OP_LDFB, OP_NOP});
    if (!wr_d)              res_d = '0;
    else if (op == OP_STFB) res_d = DW'(pack_flag_byte(flags_q));
    else                    res_d = res_pick;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_wr     <= 1'b0;
      flags_q    <= '0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_result <= res_d;
      out_wr     <= wr_d;
      flags_q    <= flags_d;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  assign out_flags = flags_q;

  // R1: a stalled result and the flag register stay put
  a_r1_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) &&
                                   $stable(out_wr) && $stable(out_flags)));

  // R5: compare and test never request a write
  a_r5_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (op == OP_CMP || op == OP_TEST)) |=> (!out_wr && out_result == '0));

  // R6: increment and decrement keep carry
  a_r6_keep_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (op == OP_INC || op == OP_DEC)) |=> (out_flags[0] == $past(out_flags[0])));

  // R7: negate carry reflects a nonzero operand
  a_r7_neg_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_NEG) |=> (out_flags[0] == ($past(b_eff) != '0)));

  // R8: bitwise operations clear overflow and carry
  a_r8_logic_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_logic) |=> (!out_flags[5] && !out_flags[0]));

  // R9: NOT, flag store and reserved opcode leave the flags alone
  a_r9_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (op == OP_NOT || op == OP_STFB || op == OP_NOP)) |=> $stable(out_flags));

  // R11: byte load keeps overflow
  a_r11_load_keeps_of: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_LDFB) |=> (out_flags[5] == $past(out_flags[5])));

endmodule

// File: tb/alu_flag_unit_tb_top.sv
`timescale 1ns/1ps
module alu_flag_unit_tb_top;

  localparam int OPC_ADD = 0, OPC_ADC = 1, OPC_SUB = 2, OPC_SBB = 3, OPC_CMP = 4,
                 OPC_INC = 5, OPC_DEC = 6, OPC_AND = 7, OPC_OR = 8, OPC_XOR = 9,
                 OPC_TEST = 10, OPC_NOT = 11, OPC_NEG = 12, OPC_LDFB = 13,
                 OPC_STFB = 14, OPC_NOP = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [1:0]  in_size = '0;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic        in_imm8 = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_wr;
  logic [5:0]  out_flags;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 1'b0;
  logic [5:0] mdl_f = '0;

  always #10 clk = ~clk;

  alu_flag_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_size(in_size), .in_a(in_a), .in_b(in_b), .in_imm8(in_imm8),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_wr(out_wr), .out_flags(out_flags)
  );

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // Reference model written from the requirements
  task automatic model(input int op, input int sz, input logic [31:0] a,
                       input logic [31:0] b, input bit imm, input logic [5:0] fin,
                       output logic [31:0] r, output bit wr, output logic [5:0] fo);
    int w;
    longint mask, msb, av, bv, x, y, cc, full, res, sx, sy, s;
    bit arith, sub, lgc;
    w    = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    mask = (longint'(1) << w) - 1;
    msb  = longint'(1) << (w - 1);
    av   = imm ? (longint'($signed(a[7:0])) & mask) : (longint'({32'd0, a}) & mask);
    bv   = longint'({32'd0, b}) & mask;
    fo = fin; res = 0; wr = 1'b1; arith = 0; sub = 0; lgc = 0;
    x = bv; y = av; cc = 0;
    case (op)
      OPC_ADD:  arith = 1;
      OPC_ADC:  begin arith = 1; cc = longint'(fin[0]); end
      OPC_SUB:  begin arith = 1; sub = 1; end
      OPC_SBB:  begin arith = 1; sub = 1; cc = longint'(fin[0]); end
      OPC_CMP:  begin arith = 1; sub = 1; wr = 0; end
      OPC_INC:  begin arith = 1; y = 1; end
      OPC_DEC:  begin arith = 1; sub = 1; y = 1; end
      OPC_NEG:  begin arith = 1; sub = 1; x = 0; y = bv; end
      OPC_AND:  begin lgc = 1; res = bv & av; end
      OPC_OR:   begin lgc = 1; res = bv | av; end
      OPC_XOR:  begin lgc = 1; res = bv ^ av; end
      OPC_TEST: begin lgc = 1; res = bv & av; wr = 0; end
      OPC_NOT:  res = ~bv & mask;
      OPC_LDFB: begin
        wr = 0;
        fo[0] = a[0]; fo[1] = a[2]; fo[2] = a[4]; fo[3] = a[6]; fo[4] = a[7];
      end
      OPC_STFB: res = longint'({fin[4], fin[3], 1'b0, fin[2], 1'b0, fin[1], 1'b0, fin[0]});
      default:  wr = 0;
    endcase
    if (arith) begin
      sx = ((x & msb) != 0) ? x - (mask + 1) : x;
      sy = ((y & msb) != 0) ? y - (mask + 1) : y;
      if (sub) begin
        full = x - y - cc;
        s    = sx - sy - cc;
        fo[2] = ((x & 15) - (y & 15) - cc) < 0;
        if (op != OPC_DEC) fo[0] = full < 0;
      end else begin
        full = x + y + cc;
        s    = sx + sy + cc;
        fo[2] = ((x & 15) + (y & 15) + cc) > 15;
        if (op != OPC_INC) fo[0] = full > mask;
      end
      res   = full & mask;
      fo[5] = (s > msb - 1) || (s < -msb);
    end
    if (arith || lgc) begin
      fo[1] = ~^res[7:0];
      fo[3] = (res == 0);
      fo[4] = (res & msb) != 0;
    end
    if (lgc) begin
      fo[0] = 1'b0;
      fo[5] = 1'b0;
    end
    r = wr ? res[31:0] : 32'd0;
  endtask

  task automatic run_op(input string rq, input int op, input int sz,
                        input logic [31:0] a, input logic [31:0] b, input bit imm);
    logic [31:0] er;
    bit          ew;
    logic [5:0]  ef;
    model(op, sz, a, b, imm, mdl_f, er, ew, ef);
    @(negedge clk);
    in_op = op[3:0]; in_size = sz[1:0]; in_a = a; in_b = b; in_imm8 = imm;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(rq, "out_valid", {31'd0, out_valid}, 32'd1);
    chk(rq, "result", out_result, er);
    chk(rq, "write", {31'd0, out_wr}, {31'd0, ew});
    chk(rq, "flags", {26'd0, out_flags}, {26'd0, ef});
    mdl_f = ef;
  endtask

  task automatic t_reset;
    chk("R13", "out_valid", {31'd0, out_valid}, 32'd0);
    chk("R13", "flags", {26'd0, out_flags}, 32'd0);
    chk("R13", "in_ready", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_add_family;
    run_op("R4 R10 add 8 signed overflow", OPC_ADD, 0, 32'hABCD_0001, 32'h1234_567F, 0);
    run_op("R4 R2 add 8 carry to zero", OPC_ADD, 0, 32'h0000_0001, 32'hFFFF_FFFF, 0);
    run_op("R4 R2 add 16 both negative", OPC_ADD, 1, 32'h0000_8000, 32'hFFFF_8000, 0);
    run_op("R4 adc 32 carry in", OPC_ADC, 2, 32'h0000_0000, 32'hFFFF_FFFF, 0);
    run_op("R4 adc 32 carry chain", OPC_ADC, 2, 32'h0000_0001, 32'h7FFF_FFFE, 0);
    run_op("R4 R10 sub 8 borrow", OPC_SUB, 0, 32'h0000_0001, 32'h0000_0000, 0);
    run_op("R4 sbb 16 borrow in", OPC_SBB, 1, 32'h0000_1234, 32'h0000_1234, 0);
    run_op("R4 R10 sub 32 min minus one", OPC_SUB, 2, 32'h0000_0001, 32'h8000_0000, 0);
    run_op("R2 size code 3 acts as 32", OPC_ADD, 3, 32'h0001_0000, 32'hFFFF_0000, 0);
  endtask

  task automatic t_imm;
    run_op("R3 imm8 sign extension 16", OPC_ADD, 1, 32'h5A5A_00F0, 32'h0000_0010, 1);
    run_op("R3 imm8 sign extension 32", OPC_SUB, 2, 32'h0000_0080, 32'h0000_0000, 1);
    run_op("R3 imm8 positive", OPC_ADD, 2, 32'hFFFF_FF7F, 32'h0000_0001, 1);
  endtask

  task automatic t_cmp_test;
    run_op("R5 cmp less than", OPC_CMP, 0, 32'h0000_0007, 32'h0000_0005, 0);
    run_op("R5 cmp equal", OPC_CMP, 2, 32'h1234_5678, 32'h1234_5678, 0);
    run_op("R5 R8 test disjoint", OPC_TEST, 0, 32'h0000_000F, 32'h0000_00F0, 0);
  endtask

  task automatic t_incdec;
    run_op("R6 set carry", OPC_ADD, 0, 32'h0000_00FF, 32'h0000_00FF, 0);
    run_op("R6 inc keeps carry set", OPC_INC, 0, 32'h0, 32'h0000_00FF, 0);
    run_op("R6 R10 inc 16 overflow", OPC_INC, 1, 32'h0, 32'h0000_7FFF, 0);
    run_op("R6 clear carry", OPC_ADD, 0, 32'h0000_0001, 32'h0000_0001, 0);
    run_op("R6 dec 32 keeps carry clear", OPC_DEC, 2, 32'h0, 32'h0000_0000, 0);
  endtask

  task automatic t_neg;
    run_op("R7 neg zero", OPC_NEG, 0, 32'h0, 32'hFFFF_FF00, 0);
    run_op("R7 neg most negative", OPC_NEG, 0, 32'h0, 32'h0000_0080, 0);
    run_op("R7 neg 16", OPC_NEG, 1, 32'h0, 32'h0000_0005, 0);
  endtask

  task automatic t_logic;
    run_op("R8 prime of and cf", OPC_ADD, 0, 32'h0000_0080, 32'h0000_0088, 0);
    run_op("R8 or", OPC_OR, 1, 32'h0000_0F00, 32'h0000_80F0, 0);
    run_op("R8 xor to zero", OPC_XOR, 2, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 0);
    run_op("R8 and 8", OPC_AND, 0, 32'h0000_00C3, 32'h0000_00A5, 0);
  endtask

  task automatic t_not;
    run_op("R9 not 16", OPC_NOT, 1, 32'h0, 32'hFFFF_1234, 0);
    run_op("R9 not 32", OPC_NOT, 2, 32'h0, 32'h0F0F_0000, 0);
    run_op("R9 reserved opcode", OPC_NOP, 2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
  endtask

  task automatic t_flag_byte;
    run_op("R11 load all ones", OPC_LDFB, 0, 32'h0000_00FF, 32'h0, 0);
    run_op("R12 store packed", OPC_STFB, 0, 32'h0, 32'h0, 0);
    chk("R12", "packed byte value", out_result, 32'h0000_00D5);
    run_op("R11 load reserved bits only", OPC_LDFB, 0, 32'h0000_002A, 32'h0, 0);
    run_op("R12 store zero", OPC_STFB, 2, 32'h0, 32'h0, 0);
    run_op("R11 set overflow", OPC_ADD, 0, 32'h0000_0001, 32'h0000_007F, 0);
    run_op("R11 load keeps overflow", OPC_LDFB, 0, 32'h0000_0041, 32'h0, 0);
  endtask

  task automatic t_stall;
    logic [31:0] rx, ry;
    bit          wx, wy;
    logic [5:0]  fx, fy;
    model(OPC_ADD, 0, 32'h1, 32'hFF, 0, mdl_f, rx, wx, fx);
    model(OPC_SUB, 1, 32'h3, 32'h1, 0, fx, ry, wy, fy);
    @(negedge clk);
    out_ready = 1'b0;
    in_op = 4'(OPC_ADD); in_size = 2'd0; in_a = 32'h1; in_b = 32'hFF; in_imm8 = 1'b0;
    in_valid = 1'b1;
    @(negedge clk);
    in_op = 4'(OPC_SUB); in_size = 2'd1; in_a = 32'h3; in_b = 32'h1;
    chk("R1", "in_ready during stall", {31'd0, in_ready}, 32'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R1", "held result", out_result, rx);
      chk("R1", "held flags", {26'd0, out_flags}, {26'd0, fx});
      chk("R1", "held valid", {31'd0, out_valid}, 32'd1);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1", "next result", out_result, ry);
    chk("R1", "next flags", {26'd0, out_flags}, {26'd0, fy});
    @(negedge clk);
    chk("R1", "valid drops when drained", {31'd0, out_valid}, 32'd0);
    mdl_f = fy;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_add_family();
    t_imm();
    t_cmp_test();
    t_incdec();
    t_neg();
    t_logic();
    t_not();
    t_flag_byte();
    t_stall();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

endmodule